// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a simple register port and a byte-level I2C engine. Software loads an address or data byte into a byte buffer, then writes a command word whose low bits ask for any mix of four operations: a start followed by the address byte, a data byte transmit, a data byte receive, and a stop. The sequencer runs the requested operations one at a time in a fixed order. Each operation is handed to the engine over a request/done handshake, and the outcome is collected in an interrupt status register.

A four-bit transfer-state code is kept in the command register. Its bit 3 marks an owned bus. A start issued while that bit is set is recorded as a repeated start. A stop issued while it is clear is reported as abnormal and does not reach the engine. When the sequence ends, the status is masked by the interrupt enable register and the interrupt output reflects what remains. Bit-level SCL/SDA timing is left to the engine. The two timing registers are storage only.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Stored write masks are 0x0071C3FF for control (offset 0x00), 0x0FFFFF0F for timing A (0x04), 0x00000007 for timing B (0x08) and 0x00007FFF for interrupt enable (0x0C). A control write with bit 1 set is dropped whole.
- R2: After reset every register reads 0. A read of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 or 0x20 returns 0xFFFFFFFF, and writes to such offsets (0x18 included) do nothing.
- R3: A command write (0x14) is accepted only when control bit 0 is set and the sequencer is idle. It replaces only command bits 15:0 and clears the whole status register. Otherwise the write is ignored.
- R4: Command bit 0 is start, bit 1 is transmit, bits 3 or 4 ask for a receive, and bit 5 is stop. They run in the order start, transmit, receive, stop. Engine op codes are 0 start, 1 send, 2 receive, 3 stop. The request stays high with op and data stable until done.
- R5: Start sends buffer bits 7:0 (address in 7:1, direction in 0). It sets state 0xA if state bit 3 is set and 0x9 otherwise. It sets status bit 0 on ACK or bit 1 on NAK, and clears command bits 0 and 1. If the engine then reports the bus not busy, the remaining operations are skipped and the state is left as is. Otherwise the state becomes 0x8.
- R6: Transmit sends buffer bits 7:0 and sets status bit 0 on ACK or bit 1 on NAK. A NAK also issues a stop op. Command bit 1 is cleared and the state returns to 0x8.
- R7: Receive places the byte in buffer bits 15:8, clears bits 7:0 and sets status bit 2. A failed read loads 0xFF without bit 2. The engine NACK flag equals command bit 4. Command bits 3 and 4 are cleared and the state returns to 0x8.
- R8: Stop with state bit 3 clear sets status bit 5 and issues no op. Otherwise it issues a stop op with state 0xB and sets status bit 4. Either way command bit 5 clears and the state ends at 0x0.
- R9: A command read returns the state code in bits 22:19, the engine bus-busy input in bit 16 and the stored command in bits 15:0.
- R10: When a sequence ends, the status is ANDed with the interrupt enable. irq_o is high when the sequencer is idle and any status bit is set.
- R11: A status write (0x10) clears the bits written as 1. A bit set by the sequencer in the same cycle stays set.
- R12: A byte buffer write (0x20) stores only data bits 7:0 and clears bits 15:8. It is ignored while the sequencer is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| eng_req_o | output | 1 | Engine operation request, held until done |
| eng_op_o | output | 2 | Engine op code |
| eng_data_o | output | 8 | Address or data byte for start and send |
| eng_nack_o | output | 1 | NACK the received byte |
| eng_done_i | input | 1 | Engine operation finished (one-cycle pulse) |
| eng_nak_i | input | 1 | NAK seen on start or send, valid with done |
| eng_fail_i | input | 1 | Receive failed, valid with done |
| eng_rdata_i | input | 8 | Received byte, valid with done |
| eng_busy_i | input | 1 | Bus owned by this master |
| busy_o | output | 1 | Sequence in progress |
| irq_o | output | 1 | Masked status pending |

## Verification
Two things can land on the status register in the same cycle: a software clear through the status register and a result bit arriving from the engine. The bench stops its automatic engine model and drives the done pulse by hand in the very cycle that a write of all ones to the status register lands. It then expects the ACK bit to survive. A command write and a buffer write are also issued while the handshake is still open. They must leave the command bits, the operation trace and the buffer untouched. Beyond that, a sweep covers every command bit combination, starting from an idle or an owned bus, under every mix of address NAK, data NAK and failed read. Each result is compared with an arithmetic model of the requirements.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int unsigned REG_AW  = 6;
  localparam int unsigned REG_DW  = 32;
  localparam int unsigned STS_W   = 15;
  localparam int unsigned CMD_W   = 16;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned BUF_W   = 2 * BYTE_W;
  localparam int unsigned STATE_W = 4;
  localparam int unsigned NUM_TIM = 2;

  localparam logic [REG_AW-1:0] OFF_CTRL  = 6'h00;
  localparam logic [REG_AW-1:0] OFF_TIM0  = 6'h04;
  localparam logic [REG_AW-1:0] OFF_INTEN = 6'h0C;
  localparam logic [REG_AW-1:0] OFF_STS   = 6'h10;
  localparam logic [REG_AW-1:0] OFF_CMD   = 6'h14;
  localparam logic [REG_AW-1:0] OFF_BUF   = 6'h20;

  localparam logic [REG_DW-1:0] CTRL_MASK = 32'h0071_C3FF;
  localparam logic [REG_DW-1:0] TIM0_MASK = 32'h0FFF_FF0F;
  localparam logic [REG_DW-1:0] TIM1_MASK = 32'h0000_0007;

  localparam int unsigned CTRL_MST = 0;
  localparam int unsigned CTRL_SLV = 1;

  localparam int unsigned CB_START  = 0;
  localparam int unsigned CB_TX     = 1;
  localparam int unsigned CB_RX     = 3;
  localparam int unsigned CB_RXLAST = 4;
  localparam int unsigned CB_STOP   = 5;

  localparam int unsigned SB_ACK  = 0;
  localparam int unsigned SB_NAK  = 1;
  localparam int unsigned SB_RX   = 2;
  localparam int unsigned SB_STOP = 4;
  localparam int unsigned SB_ABN  = 5;

  localparam int unsigned ST_OWN_BIT = 3;
  localparam logic [STATE_W-1:0] ST_IDLE   = 4'h0;
  localparam logic [STATE_W-1:0] ST_ACTIVE = 4'h8;
  localparam logic [STATE_W-1:0] ST_START  = 4'h9;
  localparam logic [STATE_W-1:0] ST_RSTART = 4'hA;
  localparam logic [STATE_W-1:0] ST_STOP   = 4'hB;
  localparam logic [STATE_W-1:0] ST_TXD    = 4'hC;
  localparam logic [STATE_W-1:0] ST_RXD    = 4'hE;

  typedef enum logic [1:0] {OP_START = 2'd0, OP_SEND = 2'd1, OP_RECV = 2'd2, OP_STOP = 2'd3} eng_op_e;

  typedef enum logic [3:0] {
    PH_IDLE, PH_START, PH_START_W, PH_START_CHK, PH_TX, PH_TX_W, PH_TX_END_W,
    PH_RX, PH_RX_W, PH_STOP, PH_STOP_W, PH_FIN
  } phase_e;

  function automatic logic [REG_DW-1:0] tim_mask(input int unsigned idx);
    return (idx == 0) ? TIM0_MASK : TIM1_MASK;
  endfunction
endpackage

// File: rtl/i2c_seq_cfg.sv
module i2c_seq_cfg
  import i2c_seq_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            ctrl_we_i,
  input  logic [NUM_TIM-1:0]              tim_we_i,
  input  logic                            inten_we_i,
  input  logic [REG_DW-1:0]               wdata_i,
  output logic [REG_DW-1:0]               ctrl_o,
  output logic [NUM_TIM-1:0][REG_DW-1:0]  tim_o,
  output logic [STS_W-1:0]                inten_o
);
  logic [REG_DW-1:0] ctrl_q;
  logic [STS_W-1:0]  inten_q;

  // slave enable is not supported: such a write is dropped entirely
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (ctrl_we_i && !wdata_i[CTRL_SLV]) ctrl_q <= wdata_i & CTRL_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inten_q <= '0;
    else if (inten_we_i) inten_q <= wdata_i[STS_W-1:0];
  end

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim
    logic [REG_DW-1:0] tim_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tim_q <= '0;
      else if (tim_we_i[g]) tim_q <= wdata_i & tim_mask(g);
    end
    assign tim_o[g] = tim_q;
  end

  assign ctrl_o  = ctrl_q;
  assign inten_o = inten_q;

  // R1
  ctrl_slv_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && wdata_i[CTRL_SLV] |=> $stable(ctrl_q));
endmodule

// File: rtl/i2c_seq_core.sv
module i2c_seq_core
  import i2c_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_we_i,
  input  logic                buf_we_i,
  input  logic                sts_we_i,
  input  logic [REG_DW-1:0]   wdata_i,
  input  logic                master_en_i,
  input  logic [STS_W-1:0]    inten_i,
  output logic [CMD_W-1:0]    cmd_o,
  output logic [STATE_W-1:0]  state_o,
  output logic [STS_W-1:0]    sts_o,
  output logic [BUF_W-1:0]    buf_o,
  output logic                busy_o,
  output logic                eng_req_o,
  output eng_op_e             eng_op_o,
  output logic [BYTE_W-1:0]   eng_data_o,
  output logic                eng_nack_o,
  input  logic                eng_done_i,
  input  logic                eng_nak_i,
  input  logic                eng_fail_i,
  input  logic [BYTE_W-1:0]   eng_rdata_i,
  input  logic                eng_busy_i
);
  phase_e              ph_q;
  logic [CMD_W-1:0]    cmd_q;
  logic [STATE_W-1:0]  st_q;
  logic [STS_W-1:0]    sts_q, sts_set, sts_clr, sts_mrg;
  logic [BUF_W-1:0]    buf_q;
  logic                req_q, nack_q;
  eng_op_e             op_q;
  logic [BYTE_W-1:0]   dat_q;
  logic                done, cmd_acc;

  assign done    = req_q & eng_done_i;
  assign cmd_acc = cmd_we_i & master_en_i & (ph_q == PH_IDLE);
  assign sts_clr = sts_we_i ? wdata_i[STS_W-1:0] : '0;

  always_comb begin
    sts_set = '0;
    if (done) begin
      unique case (ph_q)
        PH_START_W, PH_TX_W: sts_set[eng_nak_i ? SB_NAK : SB_ACK] = 1'b1;
        PH_RX_W:             sts_set[SB_RX] = !eng_fail_i;
        PH_STOP_W:           sts_set[SB_STOP] = 1'b1;
        default: ;
      endcase
    end
    if (ph_q == PH_STOP && cmd_q[CB_STOP] && !st_q[ST_OWN_BIT]) sts_set[SB_ABN] = 1'b1;
    // engine result wins over a same-cycle software clear
    sts_mrg = (sts_q & ~sts_clr) | sts_set;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            sts_q <= '0;
    else if (cmd_acc)       sts_q <= '0;
    else if (ph_q == PH_FIN) sts_q <= sts_mrg & inten_i;
    else                    sts_q <= sts_mrg;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cmd_q  <= '0;
      st_q   <= ST_IDLE;
      buf_q  <= '0;
      req_q  <= 1'b0;
      op_q   <= OP_START;
      dat_q  <= '0;
      nack_q <= 1'b0;
    end else begin
      if (done) req_q <= 1'b0;
      unique case (ph_q)
        PH_IDLE: begin
          if (cmd_acc) begin
            cmd_q <= wdata_i[CMD_W-1:0];
            ph_q  <= PH_START;
          end else if (buf_we_i) begin
            buf_q <= {{BYTE_W{1'b0}}, wdata_i[BYTE_W-1:0]};
          end
        end
        PH_START: begin
          if (cmd_q[CB_START]) begin
            st_q   <= st_q[ST_OWN_BIT] ? ST_RSTART : ST_START;
            req_q  <= 1'b1;
            op_q   <= OP_START;
            dat_q  <= buf_q[BYTE_W-1:0];
            nack_q <= 1'b0;
            ph_q   <= PH_START_W;
          end else begin
            ph_q <= PH_TX;
          end
        end
        PH_START_W: begin
          if (done) begin
            cmd_q[CB_START] <= 1'b0;
            cmd_q[CB_TX]    <= 1'b0;
            ph_q            <= PH_START_CHK;
          end
        end
        PH_START_CHK: begin
          if (!eng_busy_i) ph_q <= PH_FIN;
          else begin
            st_q <= ST_ACTIVE;
            ph_q <= PH_TX;
          end
        end
        PH_TX: begin
          if (cmd_q[CB_TX]) begin
            st_q   <= ST_TXD;
            req_q  <= 1'b1;
            op_q   <= OP_SEND;
            dat_q  <= buf_q[BYTE_W-1:0];
            nack_q <= 1'b0;
            ph_q   <= PH_TX_W;
          end else begin
            ph_q <= PH_RX;
          end
        end
        PH_TX_W: begin
          if (done) begin
            if (eng_nak_i) begin
              req_q <= 1'b1;
              op_q  <= OP_STOP;
              ph_q  <= PH_TX_END_W;
            end else begin
              cmd_q[CB_TX] <= 1'b0;
              st_q         <= ST_ACTIVE;
              ph_q         <= PH_RX;
            end
          end
        end
        PH_TX_END_W: begin
          if (done) begin
            cmd_q[CB_TX] <= 1'b0;
            st_q         <= ST_ACTIVE;
            ph_q         <= PH_RX;
          end
        end
        PH_RX: begin
          if (cmd_q[CB_RX] || cmd_q[CB_RXLAST]) begin
            st_q   <= ST_RXD;
            req_q  <= 1'b1;
            op_q   <= OP_RECV;
            nack_q <= cmd_q[CB_RXLAST];
            ph_q   <= PH_RX_W;
          end else begin
            ph_q <= PH_STOP;
          end
        end
        PH_RX_W: begin
          if (done) begin
            buf_q <= {(eng_fail_i ? {BYTE_W{1'b1}} : eng_rdata_i), {BYTE_W{1'b0}}};
            cmd_q[CB_RX]     <= 1'b0;
            cmd_q[CB_RXLAST] <= 1'b0;
            nack_q           <= 1'b0;
            st_q             <= ST_ACTIVE;
            ph_q             <= PH_STOP;
          end
        end
        PH_STOP: begin
          if (!cmd_q[CB_STOP]) ph_q <= PH_FIN;
          else if (!st_q[ST_OWN_BIT]) begin
            cmd_q[CB_STOP] <= 1'b0;
            st_q           <= ST_IDLE;
            ph_q           <= PH_FIN;
          end else begin
            st_q  <= ST_STOP;
            req_q <= 1'b1;
            op_q  <= OP_STOP;
            ph_q  <= PH_STOP_W;
          end
        end
        PH_STOP_W: begin
          if (done) begin
            cmd_q[CB_STOP] <= 1'b0;
            st_q           <= ST_IDLE;
            ph_q           <= PH_FIN;
          end
        end
        PH_FIN:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign cmd_o      = cmd_q;
  assign state_o    = st_q;
  assign sts_o      = sts_q;
  assign buf_o      = buf_q;
  assign busy_o     = (ph_q != PH_IDLE);
  assign eng_req_o  = req_q;
  assign eng_op_o   = op_q;
  assign eng_data_o = dat_q;
  assign eng_nack_o = nack_q;

  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_req_o && !eng_done_i |=> eng_req_o && $stable(eng_op_o) && $stable(eng_data_o));

  // R5
  end_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (st_q == ST_IDLE || st_q == ST_ACTIVE || st_q == ST_START || st_q == ST_RSTART));

  // R10
  fin_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (sts_q & ~$past(inten_i)) == '0);

  // R3
  cmd_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && !master_en_i && !busy_o |=> !busy_o);

  // R12
  buf_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i && busy_o && ph_q != PH_RX_W |=> $stable(buf_q));
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [5:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               eng_req_o,
  output logic [1:0]         eng_op_o,
  output logic [7:0]         eng_data_o,
  output logic               eng_nack_o,
  input  logic               eng_done_i,
  input  logic               eng_nak_i,
  input  logic               eng_fail_i,
  input  logic [7:0]         eng_rdata_i,
  input  logic               eng_busy_i,
  output logic               busy_o,
  output logic               irq_o
);
  localparam int unsigned ST_LSB = 19;
  localparam int unsigned BUSY_BIT = 16;

  logic [REG_DW-1:0]              ctrl;
  logic [NUM_TIM-1:0][REG_DW-1:0] tim;
  logic [STS_W-1:0]               inten, sts;
  logic [CMD_W-1:0]               cmd;
  logic [STATE_W-1:0]             state;
  logic [BUF_W-1:0]               bufv;
  logic [NUM_TIM-1:0]             tim_we;
  eng_op_e                        op;

  for (genvar g = 0; g < NUM_TIM; g++) begin : g_tim_dec
    assign tim_we[g] = reg_we_i && (reg_addr_i == OFF_TIM0 + REG_AW'(4 * g));
  end

  i2c_seq_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (reg_we_i && reg_addr_i == OFF_CTRL),
    .tim_we_i   (tim_we),
    .inten_we_i (reg_we_i && reg_addr_i == OFF_INTEN),
    .wdata_i    (reg_wdata_i),
    .ctrl_o     (ctrl),
    .tim_o      (tim),
    .inten_o    (inten)
  );

  i2c_seq_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (reg_we_i && reg_addr_i == OFF_CMD),
    .buf_we_i    (reg_we_i && reg_addr_i == OFF_BUF),
    .sts_we_i    (reg_we_i && reg_addr_i == OFF_STS),
    .wdata_i     (reg_wdata_i),
    .master_en_i (ctrl[CTRL_MST]),
    .inten_i     (inten),
    .cmd_o       (cmd),
    .state_o     (state),
    .sts_o       (sts),
    .buf_o       (bufv),
    .busy_o      (busy_o),
    .eng_req_o   (eng_req_o),
    .eng_op_o    (op),
    .eng_data_o  (eng_data_o),
    .eng_nack_o  (eng_nack_o),
    .eng_done_i  (eng_done_i),
    .eng_nak_i   (eng_nak_i),
    .eng_fail_i  (eng_fail_i),
    .eng_rdata_i (eng_rdata_i),
    .eng_busy_i  (eng_busy_i)
  );

  assign eng_op_o = op;
  assign irq_o    = (|sts) && !busy_o;

  always_comb begin
    reg_rdata_o = '1;
    if (reg_addr_i == OFF_CTRL) reg_rdata_o = ctrl;
    for (int i = 0; i < NUM_TIM; i++)
      if (reg_addr_i == OFF_TIM0 + REG_AW'(4 * i)) reg_rdata_o = tim[i];
    if (reg_addr_i == OFF_INTEN) reg_rdata_o = REG_DW'(inten);
    if (reg_addr_i == OFF_STS)   reg_rdata_o = REG_DW'(sts);
    if (reg_addr_i == OFF_BUF)   reg_rdata_o = REG_DW'(bufv);
    if (reg_addr_i == OFF_CMD) begin
      reg_rdata_o = '0;
      reg_rdata_o[ST_LSB +: STATE_W] = state;
      reg_rdata_o[BUSY_BIT]          = eng_busy_i;
      reg_rdata_o[CMD_W-1:0]         = cmd;
    end
  end

  // R9
  busy_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_addr_i == OFF_CMD |-> reg_rdata_o[BUSY_BIT] == eng_busy_i);
endmodule

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  logic clk = 0, rst_ni = 0;
  logic reg_we = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic eng_req, eng_nack, eng_done = 0, eng_nak = 0, eng_fail = 0, eng_busy = 0;
  logic [1:0] eng_op;
  logic [7:0] eng_data, eng_rdata = 0;
  logic busy, irq;

  int total = 0, bad = 0;
  bit auto_eng = 1;
  bit an_cur = 0, dn_cur = 0, rf_cur = 0;
  logic [7:0] rx_cur = 0, buf_cur = 0;
  int n_ops = 0;
  logic [23:0] ops_act;
  bit data_ok;

  always #5 clk = ~clk;

  i2c_cmd_seq dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .eng_req_o(eng_req),
    .eng_op_o(eng_op), .eng_data_o(eng_data), .eng_nack_o(eng_nack),
    .eng_done_i(eng_done), .eng_nak_i(eng_nak), .eng_fail_i(eng_fail),
    .eng_rdata_i(eng_rdata), .eng_busy_i(eng_busy), .busy_o(busy), .irq_o(irq)
  );

  // byte engine model: answers two cycles after a request
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (auto_eng && eng_req && !eng_done) begin
        if (cnt == 2) begin
          cnt = 0;
          if (n_ops < 8) ops_act[3*n_ops +: 3] = {eng_nack, eng_op};
          n_ops++;
          eng_nak = 0; eng_fail = 0;
          case (eng_op)
            2'd0: begin eng_nak = an_cur; eng_busy = !an_cur; if (eng_data !== buf_cur) data_ok = 0; end
            2'd1: begin eng_nak = dn_cur; if (eng_data !== buf_cur) data_ok = 0; end
            2'd2: begin eng_fail = rf_cur; eng_rdata = rx_cur; end
            default: eng_busy = 0;
          endcase
          eng_done = 1;
        end else cnt++;
      end else if (auto_eng && eng_done) eng_done = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy && t < 200) begin @(negedge clk); t++; end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0; eng_busy = 0; eng_done = 0;
    @(negedge clk); rst_ni = 1;
  endtask

  // requirement model of one command
  task automatic model(input bit pa, input logic [15:0] c0, input bit an, input bit dn, input bit rf,
                       input logic [7:0] rb, input logic [7:0] bb, input logic [14:0] en,
                       output logic [3:0] st, output logic [14:0] sts, output logic [15:0] bv,
                       output logic [15:0] c, output bit bz, output int nops, output logic [23:0] ops);
    st = pa ? 4'h8 : 4'h0; bz = pa; sts = 0; bv = {8'h00, bb}; c = c0; nops = 0; ops = 0;
    begin : seq
      if (c[0]) begin
        st = st[3] ? 4'hA : 4'h9;
        ops[3*nops +: 3] = 3'd0; nops++;
        if (an) begin sts[1] = 1; bz = 0; end else begin sts[0] = 1; bz = 1; end
        c[0] = 0; c[1] = 0;
        if (!bz) disable seq;
        st = 4'h8;
      end
      if (c[1]) begin
        ops[3*nops +: 3] = 3'd1; nops++;
        if (dn) begin sts[1] = 1; ops[3*nops +: 3] = 3'd3; nops++; bz = 0; end
        else sts[0] = 1;
        c[1] = 0; st = 4'h8;
      end
      if (c[3] | c[4]) begin
        ops[3*nops +: 3] = {c[4], 2'd2}; nops++;
        if (rf) bv = 16'hFF00; else begin bv = {rb, 8'h00}; sts[2] = 1; end
        c[3] = 0; c[4] = 0; st = 4'h8;
      end
      if (c[5]) begin
        if (!st[3]) sts[5] = 1;
        else begin ops[3*nops +: 3] = 3'd3; nops++; bz = 0; sts[4] = 1; end
        c[5] = 0; st = 4'h0;
      end
    end
    sts = sts & en;
  endtask

  initial begin
    logic [31:0] d;
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();
    // R2 reset values and unmapped reads
    rd(6'h00, d); chk("R2 ctrl reset", d, 0);
    rd(6'h0C, d); chk("R2 inten reset", d, 0);
    rd(6'h10, d); chk("R2 status reset", d, 0);
    rd(6'h14, d); chk("R2 cmd reset", d, 0);
    rd(6'h20, d); chk("R2 buf reset", d, 0);
    chk("R2 irq reset", {31'b0, irq}, 0);
    rd(6'h18, d); chk("R2 unmapped 0x18", d, 32'hFFFFFFFF);
    rd(6'h1C, d); chk("R2 unmapped 0x1C", d, 32'hFFFFFFFF);
    rd(6'h02, d); chk("R2 unaligned", d, 32'hFFFFFFFF);
    // R1 write masks
    wr(6'h00, 32'hFFFFFFFF); rd(6'h00, d); chk("R1 ctrl slave write dropped", d, 0);
    wr(6'h00, 32'hFFFFFFFD); rd(6'h00, d); chk("R1 ctrl mask", d, 32'h0071C3FD);
    wr(6'h04, 32'hFFFFFFFF); rd(6'h04, d); chk("R1 timing A mask", d, 32'h0FFFFF0F);
    wr(6'h08, 32'hFFFFFFFF); rd(6'h08, d); chk("R1 timing B mask", d, 32'h7);
    wr(6'h0C, 32'hFFFFFFFF); rd(6'h0C, d); chk("R1 inten mask", d, 32'h7FFF);
    wr(6'h18, 32'h12345678); rd(6'h00, d); chk("R2 write to 0x18 ignored", d, 32'h0071C3FD);
    // R12 buffer write width
    wr(6'h20, 32'hFFFF_ABCD); rd(6'h20, d); chk("R12 buf keeps 7:0", d, 32'h000000CD);
    // R3 command ignored with master disabled
    wr(6'h00, 32'h0); n_ops = 0;
    wr(6'h14, 32'h0000_0021);
    repeat (8) @(negedge clk);
    chk("R3 disabled no busy", {31'b0, busy}, 0);
    chk("R3 disabled no op", n_ops, 0);
    rd(6'h14, d); chk("R3 disabled cmd unchanged", d, 0);

    // R11/R12/R3 collision: manual engine
    do_reset(); auto_eng = 0;
    wr(6'h00, 1); wr(6'h0C, 32'h7FFF); wr(6'h20, 32'h5A);
    wr(6'h14, 32'h1);
    repeat (3) @(negedge clk);
    chk("R4 request raised", {31'b0, eng_req}, 1);
    chk("R5 start op and address", {22'b0, eng_op, eng_data}, {22'b0, 2'd0, 8'h5A});
    wr(6'h14, 32'h20);
    wr(6'h20, 32'h11);
    chk("R4 request held", {31'b0, eng_req}, 1);
    @(negedge clk); eng_done = 1; eng_nak = 0; eng_busy = 1;
    reg_we = 1; reg_addr = 6'h10; reg_wdata = 32'h7FFF;
    @(negedge clk); eng_done = 0; reg_we = 0;
    wait_idle();
    rd(6'h10, d); chk("R11 set wins over clear", d, 32'h1);
    chk("R10 irq after sequence", {31'b0, irq}, 1);
    rd(6'h14, d); chk("R3 busy command ignored", d, {9'b0, 4'h8, 2'b0, 1'b1, 16'h0});
    rd(6'h20, d); chk("R12 busy buf write ignored", d, 32'h5A);
    wr(6'h10, 32'h1); rd(6'h10, d); chk("R11 write one clears", d, 0);
    chk("R10 irq cleared", {31'b0, irq}, 0);
    auto_eng = 1;

    // sweep
    for (int cmd = 0; cmd < 64; cmd++)
      for (int v = 0; v < 16; v++) begin
        bit pa, an, dn, rf, bz;
        logic [14:0] en, sts_e;
        logic [3:0] st_e;
        logic [15:0] bv_e, c_e, cw;
        logic [23:0] ops_e;
        int nops_e;
        pa = v[0]; an = v[1]; dn = v[2]; rf = v[3];
        en = (v % 3 == 0) ? 15'h7FFF : ((v % 3 == 1) ? 15'h0013 : 15'h0034);
        do_reset();
        wr(6'h00, 1); wr(6'h0C, {17'b0, en});
        if (pa) begin an_cur = 0; buf_cur = 8'h50; wr(6'h20, 32'h50); wr(6'h14, 32'h1); wait_idle(); end
        buf_cur = 8'hA4 ^ 8'(cmd); rx_cur = 8'h3C ^ 8'(cmd * 5 + v);
        an_cur = an; dn_cur = dn; rf_cur = rf;
        wr(6'h20, {24'hFFFFFF, buf_cur});
        n_ops = 0; ops_act = 0; data_ok = 1;
        cw = {10'h155, 6'(cmd)};
        wr(6'h14, {16'hFFFF, cw});
        wait_idle();
        model(pa, cw, an, dn, rf, rx_cur, buf_cur, en, st_e, sts_e, bv_e, c_e, bz, nops_e, ops_e);
        rd(6'h14, d);
        chk($sformatf("R5 R8 state cmd=%0d v=%0d", cmd, v), {28'b0, d[22:19]}, {28'b0, st_e});
        chk($sformatf("R9 busy bit cmd=%0d v=%0d", cmd, v), {31'b0, d[16]}, {31'b0, bz});
        chk($sformatf("R3 R6 R7 cmd bits cmd=%0d v=%0d", cmd, v), {16'b0, d[15:0]}, {16'b0, c_e});
        rd(6'h10, d);
        chk($sformatf("R10 status cmd=%0d v=%0d", cmd, v), d, {17'b0, sts_e});
        rd(6'h20, d);
        chk($sformatf("R7 buffer cmd=%0d v=%0d", cmd, v), d, {16'b0, bv_e});
        chk($sformatf("R4 op count cmd=%0d v=%0d", cmd, v), n_ops, nops_e);
        chk($sformatf("R4 op trace cmd=%0d v=%0d", cmd, v), {8'b0, ops_act}, {8'b0, ops_e});
        chk($sformatf("R6 byte sent cmd=%0d v=%0d", cmd, v), {31'b0, data_ok}, 1);
      end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule